// File: doc/BRIEF.md
# Bus-Snooping Memory Address Unit

Each memory unit on a shared 8-bit bus keeps its own copies of the machine's address registers: the program counter, the stack register and the data counter. A build-time option adds a buffer for the data counter. On every bus cycle the processor broadcasts a 5-bit control code. Every unit decodes that code and updates its copies in the same way, so the copies stay equal across all units without any exchange between them.

A unit owns one 1 KB window of the 16-bit address space. The window is given by a build-time mask that is compared against the top six bits of whichever register the code uses. Only a unit whose window holds that address answers on the bus. The unit has a local byte array that the testbench fills through a plain load port before any bus traffic starts.

The bus has no back-pressure and no valid/ready handshake. Every strobed cycle completes on the clock edge that ends it, and the processor cannot stall a unit. The drive enable, the select flag and the driven byte are combinational within the cycle. A system with several units resolves the shared bus outside the block and feeds the resolved byte back on `bus_in`.

Top module: `addr_snoop_unit`

## Requirements
- R1: An active-low synchronous reset clears the program counter, the stack register, the data counter and the data counter buffer to 0x0000.
- R2: A unit is selected only when bits 15..10 of the register the code uses equal its mask. For example, mask 1 covers 0x0400 to 0x07FF. A unit drives the bus only while it is selected and the code reads. Units with disjoint masks never drive in the same cycle.
- R3: Code 0x00 (fetch) and code 0x03 (immediate operand) put the byte at the program counter on the bus. Every unit then adds one to the program counter.
- R4: Code 0x01 puts the byte at the program counter on the bus. Every unit then adds that byte, sign-extended from 8 to 16 bits, to the program counter.
- R5: Code 0x02 puts the byte at the data counter on the bus. Code 0x05 writes the bus byte into memory at the data counter and does not drive. After either code every unit adds one to the data counter.
- R6: Code 0x04 copies the stack register into the program counter. Code 0x0D loads the stack register with the program counter plus one and leaves the program counter unchanged.
- R7: Code 0x0A adds the bus byte, sign-extended, to the data counter.
- R8: Codes 0x0C, 0x0E and 0x11 read the byte at the program counter and take the bus byte into, in that order, the program counter low byte, the data counter low byte and the data counter high byte. The program counter does not advance.
- R9: Code 0x12 copies the program counter into the stack register and loads the bus byte into the program counter low byte. Code 0x14 loads the bus byte into the program counter high byte.
- R10: Code 0x1E drives the program counter low byte and code 0x1F drives its high byte, from the unit whose window holds the program counter. Code 0x0B drives the stack register low byte from the unit whose window holds the stack register.
- R11: Code 0x1D swaps the data counter with its buffer in units built with the buffer. Units built without the buffer leave the data counter unchanged.
- R12: With the cycle strobe low, or with code 0x1C or any code not listed above, no register changes and the unit neither drives nor selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rising edge ends a bus cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | High when the current bus cycle carries a code |
| ctl_code | input | 5 | Broadcast control code |
| bus_in | input | 8 | Resolved shared data bus byte |
| bus_out | output | 8 | Byte this unit offers to the bus |
| bus_drive | output | 1 | High when this unit drives the bus |
| sel | output | 1 | High when this unit considers itself addressed |
| ld_en | input | 1 | Write enable for the local memory load port |
| ld_addr | input | 10 | Load port byte address |
| ld_data | input | 8 | Load port data |

## Verification
A wrong register copy in one unit shows up as a wrong owner. It appears on the first cycle whose pointer crosses a window edge: either no unit answers or two units answer at once. The bench therefore runs two units with different windows and checks, every cycle, which unit drives and selects. A wrong value shows up on the next read code that uses that register. This is immediate for the program counter through codes 0x1E and 0x1F. For the data counter it appears one cycle later, at the next 0x02 read of a known memory byte. A swap that reaches a unit built without the buffer appears at the next data read, because the wrong unit answers.

// File: rtl/addr_snoop_pkg.sv
package addr_snoop_pkg;

  localparam logic [4:0] CC_FETCH   = 5'h00;
  localparam logic [4:0] CC_REL_PC  = 5'h01;
  localparam logic [4:0] CC_RD_DC   = 5'h02;
  localparam logic [4:0] CC_IMM     = 5'h03;
  localparam logic [4:0] CC_RET     = 5'h04;
  localparam logic [4:0] CC_WR_DC   = 5'h05;
  localparam logic [4:0] CC_ADD_DC  = 5'h0A;
  localparam logic [4:0] CC_SP_LO   = 5'h0B;
  localparam logic [4:0] CC_LD_PCL  = 5'h0C;
  localparam logic [4:0] CC_LINK    = 5'h0D;
  localparam logic [4:0] CC_LD_DCL  = 5'h0E;
  localparam logic [4:0] CC_LD_DCH  = 5'h11;
  localparam logic [4:0] CC_CALL    = 5'h12;
  localparam logic [4:0] CC_SET_PCH = 5'h14;
  localparam logic [4:0] CC_NOP     = 5'h1C;
  localparam logic [4:0] CC_SWAP_DC = 5'h1D;
  localparam logic [4:0] CC_PC_LO   = 5'h1E;
  localparam logic [4:0] CC_PC_HI   = 5'h1F;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_MEM,
    SRC_PC_LO,
    SRC_PC_HI,
    SRC_SP_LO
  } drv_src_e;

  typedef enum logic [1:0] {
    PTR_PC,
    PTR_DC,
    PTR_SP
  } ptr_sel_e;

  typedef struct packed {
    drv_src_e src;
    ptr_sel_e ptr;
    logic     access;
    logic     wr;
  } cyc_dec_t;

endpackage

// File: rtl/asu_decode.sv
module asu_decode
  import addr_snoop_pkg::*;
(
  input  logic [4:0] code,
  output cyc_dec_t   dec
);

  always_comb begin
    dec = '{src: SRC_NONE, ptr: PTR_PC, access: 1'b0, wr: 1'b0};
    case (code)
      CC_FETCH, CC_IMM, CC_REL_PC, CC_LD_PCL, CC_LD_DCL, CC_LD_DCH:
        dec = '{src: SRC_MEM, ptr: PTR_PC, access: 1'b1, wr: 1'b0};
      CC_RD_DC:
        dec = '{src: SRC_MEM, ptr: PTR_DC, access: 1'b1, wr: 1'b0};
      CC_WR_DC:
        dec = '{src: SRC_NONE, ptr: PTR_DC, access: 1'b1, wr: 1'b1};
      CC_SP_LO:
        dec = '{src: SRC_SP_LO, ptr: PTR_SP, access: 1'b1, wr: 1'b0};
      CC_PC_LO:
        dec = '{src: SRC_PC_LO, ptr: PTR_PC, access: 1'b1, wr: 1'b0};
      CC_PC_HI:
        dec = '{src: SRC_PC_HI, ptr: PTR_PC, access: 1'b1, wr: 1'b0};
      default: ;
    endcase
  end

endmodule

// File: rtl/asu_regs.sv
module asu_regs
  import addr_snoop_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 8,
  parameter bit          HAS_DC1 = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [4:0]    code,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] pc0,
  output logic [AW-1:0] pc1,
  output logic [AW-1:0] dc0
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] bus_sx;
  logic [AW-1:0] dc1_w;
  logic          swap_en;

  assign bus_sx  = {{(AW-DW){bus_in[DW-1]}}, bus_in};
  assign swap_en = upd && (code == CC_SWAP_DC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc0 <= '0;
      pc1 <= '0;
      dc0 <= '0;
    end else if (upd) begin
      case (code)
        CC_FETCH, CC_IMM: pc0 <= pc0 + ONE;
        CC_REL_PC:        pc0 <= pc0 + bus_sx;
        CC_RD_DC, CC_WR_DC: dc0 <= dc0 + ONE;
        CC_RET:           pc0 <= pc1;
        CC_ADD_DC:        dc0 <= dc0 + bus_sx;
        CC_LD_PCL:        pc0[DW-1:0] <= bus_in;
        CC_LINK:          pc1 <= pc0 + ONE;
        CC_LD_DCL:        dc0[DW-1:0] <= bus_in;
        CC_LD_DCH:        dc0[AW-1:AW-DW] <= bus_in;
        CC_CALL: begin
          pc1         <= pc0;
          pc0[DW-1:0] <= bus_in;
        end
        CC_SET_PCH:       pc0[AW-1:AW-DW] <= bus_in;
        CC_SWAP_DC:       if (HAS_DC1) dc0 <= dc1_w;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_DC1) begin : g_dc1
      logic [AW-1:0] dc1_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       dc1_q <= '0;
        else if (swap_en) dc1_q <= dc0;
      end
      assign dc1_w = dc1_q;
    end else begin : g_no_dc1
      assign dc1_w = '0;
      // R11: a unit without the buffer keeps its data counter on a swap
      p_noswap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en |=> $stable(dc0));
    end
  endgenerate

  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd && (code == CC_FETCH || code == CC_IMM) |=> pc0 == $past(pc0) + ONE);

  p_dc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd && (code == CC_RD_DC || code == CC_WR_DC) |=> dc0 == $past(dc0) + ONE);

  p_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd && code == CC_LINK |=> (pc1 == $past(pc0) + ONE) && $stable(pc0));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(pc0) && $stable(pc1) && $stable(dc0));

endmodule

// File: rtl/asu_mem.sv
module asu_mem #(
  parameter int unsigned DW  = 8,
  parameter int unsigned MAW = 10
) (
  input  logic           clk,
  input  logic [MAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic           wr_en,
  input  logic [MAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           ld_en,
  input  logic [MAW-1:0] ld_addr,
  input  logic [DW-1:0]  ld_data
);

  localparam int unsigned DEPTH = 1 << MAW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en)      mem[ld_addr] <= ld_data;
    else if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/addr_snoop_unit.sv
module addr_snoop_unit
  import addr_snoop_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 8,
  parameter int unsigned MAW     = 10,
  parameter int unsigned MASK    = 0,
  parameter bit          HAS_DC1 = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cyc_valid,
  input  logic [4:0]     ctl_code,
  input  logic [DW-1:0]  bus_in,
  output logic [DW-1:0]  bus_out,
  output logic           bus_drive,
  output logic           sel,
  input  logic           ld_en,
  input  logic [MAW-1:0] ld_addr,
  input  logic [DW-1:0]  ld_data
);

  localparam int unsigned MW = AW - MAW;
  localparam logic [MW-1:0] WIN = MW'(MASK);

  cyc_dec_t      dec;
  logic [AW-1:0] pc0, pc1, dc0;
  logic [AW-1:0] ptr;
  logic [DW-1:0] mem_rd;
  logic          hit;

  asu_decode u_dec (
    .code (ctl_code),
    .dec  (dec)
  );

  asu_regs #(.AW(AW), .DW(DW), .HAS_DC1(HAS_DC1)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (cyc_valid),
    .code   (ctl_code),
    .bus_in (bus_in),
    .pc0    (pc0),
    .pc1    (pc1),
    .dc0    (dc0)
  );

  always_comb begin
    case (dec.ptr)
      PTR_DC:  ptr = dc0;
      PTR_SP:  ptr = pc1;
      default: ptr = pc0;
    endcase
  end

  assign hit       = ptr[AW-1:MAW] == WIN;
  assign sel       = cyc_valid && dec.access && hit;
  assign bus_drive = sel && !dec.wr;

  asu_mem #(.DW(DW), .MAW(MAW)) u_mem (
    .clk     (clk),
    .rd_addr (ptr[MAW-1:0]),
    .rd_data (mem_rd),
    .wr_en   (sel && dec.wr),
    .wr_addr (dc0[MAW-1:0]),
    .wr_data (bus_in),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_data (ld_data)
  );

  always_comb begin
    case (dec.src)
      SRC_MEM:   bus_out = mem_rd;
      SRC_PC_LO: bus_out = pc0[DW-1:0];
      SRC_PC_HI: bus_out = pc0[AW-1:AW-DW];
      SRC_SP_LO: bus_out = pc1[DW-1:0];
      default:   bus_out = '0;
    endcase
  end

  // R2: driving implies this unit is selected in a strobed cycle
  p_drive_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> sel && cyc_valid);

  // R12: the no-op code never selects
  p_nop_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_code == CC_NOP |-> !sel && !bus_drive);

  // R5: a write cycle never drives the bus
  p_write_nodrive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_code == CC_WR_DC |-> !bus_drive);

endmodule

// File: tb/test_addr_snoop_unit.sv
`timescale 1ns/1ps
module test_addr_snoop_unit;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic [4:0]  code = 5'h1C;
  logic [7:0]  cpu_bus = 8'h00;
  logic        ld_en = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [7:0]  ld_a = '0, ld_b = '0;
  logic [7:0]  out_a, out_b;
  logic        drv_a, drv_b, sel_a, sel_b;
  logic [7:0]  bus;

  assign bus = drv_a ? out_a : (drv_b ? out_b : cpu_bus);

  addr_snoop_unit #(.MASK(0), .HAS_DC1(1'b1)) i_addr_snoop_unit (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .ctl_code(code),
    .bus_in(bus), .bus_out(out_a), .bus_drive(drv_a), .sel(sel_a),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_a));

  addr_snoop_unit #(.MASK(1), .HAS_DC1(1'b0)) i_addr_snoop_unit_b (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .ctl_code(code),
    .bus_in(bus), .bus_out(out_b), .bus_drive(drv_b), .sel(sel_b),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_b));

  typedef struct {
    bit         da, db, sa, sb;
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_pc0 = '0, m_pc1 = '0, m_dc0a = '0, m_dc1a = '0, m_dc0b = '0;
  logic [7:0]  mem_a [1024];
  logic [7:0]  mem_b [1024];

  function automatic logic [15:0] sx(input logic [7:0] b);
    return {{8{b[7]}}, b};
  endfunction

  task automatic step(input logic [4:0] c, input logic [7:0] cpu, input bit v, input string tag);
    exp_t e;
    logic [15:0] pa, pb;
    bit acc, wr, memsrc;
    logic [7:0] va, vb, b;
    acc = 1'b1; wr = 1'b0; memsrc = 1'b0;
    pa = m_pc0; pb = m_pc0;
    case (c)
      5'h00, 5'h01, 5'h03, 5'h0C, 5'h0E, 5'h11: memsrc = 1'b1;
      5'h02: begin memsrc = 1'b1; pa = m_dc0a; pb = m_dc0b; end
      5'h05: begin wr = 1'b1; pa = m_dc0a; pb = m_dc0b; end
      5'h0B: begin pa = m_pc1; pb = m_pc1; end
      5'h1E, 5'h1F: ;
      default: acc = 1'b0;
    endcase
    e.sa = v && acc && (pa[15:10] == 6'd0);
    e.sb = v && acc && (pb[15:10] == 6'd1);
    e.da = e.sa && !wr;
    e.db = e.sb && !wr;
    if (memsrc) begin va = mem_a[pa[9:0]]; vb = mem_b[pb[9:0]]; end
    else if (c == 5'h1E) begin va = m_pc0[7:0]; vb = va; end
    else if (c == 5'h1F) begin va = m_pc0[15:8]; vb = va; end
    else begin va = m_pc1[7:0]; vb = va; end
    b = e.da ? va : (e.db ? vb : cpu);
    e.val = b;
    e.tag = tag;
    @(negedge clk);
    #1;
    code = c; cpu_bus = cpu; cyc_valid = v;
    q.push_back(e);
    if (v) begin
      case (c)
        5'h00, 5'h03: m_pc0 = m_pc0 + 16'd1;
        5'h01: m_pc0 = m_pc0 + sx(b);
        5'h02: begin m_dc0a = m_dc0a + 16'd1; m_dc0b = m_dc0b + 16'd1; end
        5'h05: begin
          if (e.sa) mem_a[pa[9:0]] = b;
          if (e.sb) mem_b[pb[9:0]] = b;
          m_dc0a = m_dc0a + 16'd1; m_dc0b = m_dc0b + 16'd1;
        end
        5'h04: m_pc0 = m_pc1;
        5'h0A: begin m_dc0a = m_dc0a + sx(b); m_dc0b = m_dc0b + sx(b); end
        5'h0C: m_pc0[7:0] = b;
        5'h0D: m_pc1 = m_pc0 + 16'd1;
        5'h0E: begin m_dc0a[7:0] = b; m_dc0b[7:0] = b; end
        5'h11: begin m_dc0a[15:8] = b; m_dc0b[15:8] = b; end
        5'h12: begin m_pc1 = m_pc0; m_pc0[7:0] = b; end
        5'h14: m_pc0[15:8] = b;
        5'h1D: begin pa = m_dc0a; m_dc0a = m_dc1a; m_dc1a = pa; end
        default: ;
      endcase
    end
  endtask

  // Monitor: pops one expected item per cycle, samples before the rising edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #3;
      if (drv_a && drv_b) begin
        errors++;
        $display("FAIL R2 both units drive: actual a=%0b b=%0b expected at most one", drv_a, drv_b);
      end
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (drv_a !== e.da || drv_b !== e.db || sel_a !== e.sa || sel_b !== e.sb || bus !== e.val) begin
          errors++;
          $display("FAIL %s actual drv=%0b%0b sel=%0b%0b bus=%02h expected drv=%0b%0b sel=%0b%0b bus=%02h",
                   e.tag, drv_a, drv_b, sel_a, sel_b, bus, e.da, e.db, e.sa, e.sb, e.val);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem_a[i] = 8'((i * 37 + 11) & 255);
      mem_b[i] = 8'((i * 53 + 156) & 255);
    end
    repeat (2) @(negedge clk);
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      #1;
      ld_en = 1'b1; ld_addr = 10'(i); ld_a = mem_a[i]; ld_b = mem_b[i];
    end
    @(negedge clk);
    #1;
    ld_en = 1'b0;
    @(negedge clk);
    #3;
    checks++;
    if (drv_a || drv_b || sel_a || sel_b) begin
      errors++;
      $display("FAIL R1 quiet in reset: actual drv=%0b%0b sel=%0b%0b expected 0000", drv_a, drv_b, sel_a, sel_b);
    end
    #1;
    rst_n = 1'b1;
    step(5'h1E, 8'h00, 1'b1, "R1 pc low after reset");
    step(5'h1F, 8'h00, 1'b1, "R1 pc high after reset");
    step(5'h14, 8'h04, 1'b1, "R9 set pc high");
    step(5'h0C, 8'h00, 1'b1, "R8 load pc low from memory");
    step(5'h1E, 8'h00, 1'b1, "R10 pc low in upper window");
    step(5'h00, 8'h00, 1'b1, "R3 fetch");
    step(5'h03, 8'h00, 1'b1, "R3 immediate");
    step(5'h01, 8'h00, 1'b1, "R4 relative add");
    step(5'h01, 8'h00, 1'b1, "R4 relative add again");
    step(5'h1E, 8'h00, 1'b1, "R4 pc low after adds");
    step(5'h1F, 8'h00, 1'b1, "R2 owner of pc high");
    step(5'h0D, 8'h00, 1'b1, "R6 link");
    step(5'h14, 8'h00, 1'b1, "R9 move pc to lower window");
    step(5'h1F, 8'h00, 1'b1, "R2 lower window owns pc");
    step(5'h04, 8'h00, 1'b1, "R6 return from stack");
    step(5'h1E, 8'h00, 1'b1, "R6 pc low after return");
    step(5'h0B, 8'h00, 1'b1, "R10 stack low byte");
    step(5'h12, 8'h55, 1'b1, "R9 call");
    step(5'h1E, 8'h00, 1'b1, "R9 pc low after call");
    step(5'h0B, 8'h00, 1'b1, "R9 stack after call");
    step(5'h14, 8'h09, 1'b1, "R2 pc outside all windows");
    step(5'h00, 8'h3C, 1'b1, "R2 nobody answers");
    step(5'h11, 8'h04, 1'b1, "R8 data counter high");
    step(5'h0E, 8'h20, 1'b1, "R8 data counter low");
    step(5'h02, 8'h00, 1'b1, "R5 data read");
    step(5'h05, 8'hA7, 1'b1, "R5 data write");
    step(5'h0A, 8'hFF, 1'b1, "R7 add minus one");
    step(5'h02, 8'h00, 1'b1, "R5 read back written byte");
    step(5'h0A, 8'h7F, 1'b1, "R7 add positive");
    step(5'h02, 8'h00, 1'b0, "R12 strobe low");
    step(5'h07, 8'h00, 1'b1, "R12 unlisted code");
    step(5'h13, 8'h00, 1'b1, "R12 interrupt code ignored");
    step(5'h1C, 8'h00, 1'b1, "R12 no-op");
    step(5'h02, 8'h00, 1'b1, "R12 data counter kept");
    step(5'h11, 8'h08, 1'b1, "R8 park data counter high");
    step(5'h0E, 8'h00, 1'b1, "R8 park data counter low");
    step(5'h1D, 8'h00, 1'b1, "R11 swap");
    step(5'h02, 8'h00, 1'b1, "R11 buffered unit read");
    step(5'h11, 8'h04, 1'b1, "R8 data counter high again");
    step(5'h0E, 8'h30, 1'b1, "R8 data counter low again");
    step(5'h1D, 8'h00, 1'b1, "R11 second swap");
    step(5'h02, 8'h00, 1'b1, "R11 unbuffered unit kept counter");
    @(negedge clk);
    #1;
    cyc_valid = 1'b0;
    code = 5'h1C;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule